// File: doc/BRIEF.md
# Telecom Codec Data FIFO Port

This block is the data port for the telecom channel of a serial codec link. A processor-side 32-bit register port sits on one side and a 64-bit framed serial stream on the other. A bus write queues one telecom sample in a transmit FIFO. A bus read takes the oldest captured sample out of a receive FIFO. Samples are 14 bits wide and are carried left-justified in bits 15..2 of the word. Bits 1..0 are always zero and bits 31..16 are reserved.

The serial side runs one bit per clock. A one-cycle `frm_sync` pulse starts a 64-bit subframe, and `frm_sub0` marks that subframe as subframe 0. At the start of each subframe 0, the head of the transmit FIFO is placed in the telecom slot of the outgoing frame and shifted out most significant bit first. During each subframe 0, the same slot position is collected from `sdi` and queued in the receive FIFO. Sticky flags record four events: dropped writes, empty-FIFO reads, missing transmit samples and dropped captures. Driving `port_en` low empties both FIFOs and clears the flags.

Top module: `telecom_data_port`

## Requirements
- R1: A write stores `{wdata[15:2],2'b00}` as a transmit entry. Bits 31..16 and bits 1..0 of `wdata` have no effect on the stored entry.
- R2: A read (`rd_en` sampled on a clock edge) drives `rdata` from that edge onward with the oldest receive entry in bits 15..2, and zeros in bits 31..16 and 1..0. The read removes that entry.
- R3: Each FIFO holds DEPTH (8) entries and delivers them in arrival order. `*_level` gives the entry count, `*_full` is set at DEPTH entries and `*_empty` is set at zero entries.
- R4: A write while the transmit FIFO is full is dropped and sets the sticky `tx_ovr` flag.
- R5: A read while the receive FIFO is empty returns zero in `rdata` and sets the sticky `rx_urun` flag.
- R6: A `frm_sync` edge with `frm_sub0`=1 pops the transmit head into frame bits 47..32. All other frame bits are zero. `sdo` carries frame bit 63-(k-1) in the k-th cycle after the sync edge, so bit 47 is in cycle 17. A subframe with `frm_sub0`=0 sends all zeros and pops nothing.
- R7: If the transmit FIFO is empty at a subframe 0 sync, the slot is sent as zeros and the sticky `tx_urun` flag is set.
- R8: In subframe 0, the 64 `sdi` bits taken on the edges after sync (MSB first) form a frame. Its bits 47..34, with bits 1..0 zeroed and no right shift, are pushed into the receive FIFO on the 64th edge. Subframes with `frm_sub0`=0 are not captured.
- R9: A capture arriving while the receive FIFO is full is dropped and sets the sticky `rx_ovr` flag.
- R10: After reset, and on the edge after `port_en` is seen low, both FIFOs are empty and all four flags are zero. While `port_en` is low, writes, reads and captures leave the FIFOs empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, also the serial bit clock |
| rst_n | input | 1 | Active-low synchronous reset |
| port_en | input | 1 | Port enable; low flushes both FIFOs and flags |
| wr_en | input | 1 | Bus write strobe |
| rd_en | input | 1 | Bus read strobe |
| wdata | input | 32 | Bus write data |
| rdata | output | 32 | Bus read data, registered |
| frm_sync | input | 1 | One-cycle subframe start pulse |
| frm_sub0 | input | 1 | Qualifies the subframe as subframe 0 |
| sdi | input | 1 | Serial receive data |
| sdo | output | 1 | Serial transmit data |
| tx_full | output | 1 | Transmit FIFO full |
| tx_empty | output | 1 | Transmit FIFO empty |
| tx_level | output | 4 | Transmit FIFO entry count |
| rx_full | output | 1 | Receive FIFO full |
| rx_empty | output | 1 | Receive FIFO empty |
| rx_level | output | 4 | Receive FIFO entry count |
| tx_ovr | output | 1 | Sticky: write dropped on full transmit FIFO |
| tx_urun | output | 1 | Sticky: subframe 0 found transmit FIFO empty |
| rx_ovr | output | 1 | Sticky: capture dropped on full receive FIFO |
| rx_urun | output | 1 | Sticky: read of empty receive FIFO |

## Verification
The assertions are checked on every cycle. They cover these invariants:
- no FIFO count beyond DEPTH;
- drops happen only when a FIFO is full;
- both FIFOs are empty after a disable;
- the read word keeps its reserved and low bits at zero;
- only the telecom slot of a loaded frame can be non-zero, and a subframe 1 frame is all zero;
- flags stay set once raised.

Ordering across many entries, the exact position of each slot bit on `sdo`, capture of the right `sdi` bits, and the values returned after overrun and underrun can only be shown by the bench. Its scenarios drive frames and bus traffic against a queue model.

// File: rtl/tdp_pkg.sv
package tdp_pkg;
  localparam int unsigned FRAME_BITS = 64;
  localparam int unsigned SLOT_BITS  = 16;
  localparam int unsigned SLOT_LSB   = 32;
  localparam int unsigned BUS_BITS   = 32;
  localparam int unsigned CNT_BITS   = $clog2(FRAME_BITS);

  typedef logic [SLOT_BITS-1:0]  slot_t;
  typedef logic [FRAME_BITS-1:0] frame_t;

  // Transmit entry: bits 15..2 of the bus word, low pair cleared
  function automatic slot_t tx_entry(input logic [BUS_BITS-1:0] w);
    return {w[SLOT_BITS-1:2], 2'b00};
  endfunction

  // Place a slot into an otherwise silent frame
  function automatic frame_t frame_of(input slot_t s);
    frame_t f;
    f = '0;
    f[SLOT_LSB +: SLOT_BITS] = s;
    return f;
  endfunction

  // Extract the received slot, left justified, low pair cleared
  function automatic slot_t slot_of(input frame_t f);
    return {f[SLOT_LSB+SLOT_BITS-1:SLOT_LSB+2], 2'b00};
  endfunction

  // Bus view of a receive entry: reserved half zero
  function automatic logic [BUS_BITS-1:0] bus_word(input slot_t s);
    return {{(BUS_BITS-SLOT_BITS){1'b0}}, s[SLOT_BITS-1:2], 2'b00};
  endfunction
endpackage

// File: rtl/tdp_fifo.sv
module tdp_fifo #(
  parameter int unsigned W     = 16,
  parameter int unsigned DEPTH = 8,
  localparam int unsigned AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          push,
  input  logic [W-1:0]  din,
  input  logic          pop,
  output logic [W-1:0]  dout,
  output logic          full,
  output logic          empty,
  output logic [CW-1:0] level,
  output logic          drop
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] cnt;
  logic          do_push, do_pop;

  assign full    = (cnt == CW'(DEPTH));
  assign empty   = (cnt == '0);
  assign level   = cnt;
  assign do_pop  = pop && !empty && !flush;
  assign do_push = push && !flush && (!full || do_pop);
  assign drop    = push && !flush && !do_push;
  assign dout    = mem[rp];

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (do_push) wp <= nxt(wp);
      if (do_pop)  rp <= nxt(rp);
      case ({do_push, do_pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n) cnt <= CW'(DEPTH)); // R3
  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n) flush |=> empty); // R10
  AST_DROP_ONLY_FULL: assert property (@(posedge clk) disable iff (!rst_n) drop |-> full); // R4
endmodule

// File: rtl/tdp_txfrm.sv
module tdp_txfrm
  import tdp_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  en,
  input  logic  sync,
  input  logic  sub0,
  input  slot_t head,
  input  logic  empty,
  output logic  pop,
  output logic  slot_miss,
  output logic  sdo
);
  frame_t sh;
  slot_t  slot;
  logic   want;

  assign want      = sync && sub0 && en;
  assign pop       = want && !empty;
  assign slot_miss = want && empty;
  assign slot      = pop ? head : '0;
  assign sdo       = sh[FRAME_BITS-1];

  always_ff @(posedge clk) begin
    if (!rst_n)    sh <= '0;
    else if (sync) sh <= frame_of(slot);
    else           sh <= {sh[FRAME_BITS-2:0], 1'b0};
  end

  AST_SLOT_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    sync |=> (sh[FRAME_BITS-1:SLOT_LSB+SLOT_BITS] == '0) && (sh[SLOT_LSB-1:0] == '0)); // R6
  AST_SUB1_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (sync && !sub0) |=> (sh == '0)); // R6
  AST_MISS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    slot_miss |=> (sh == '0)); // R7
endmodule

// File: rtl/tdp_rxcap.sv
module tdp_rxcap
  import tdp_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  en,
  input  logic  sync,
  input  logic  sub0,
  input  logic  sdi,
  output logic  push,
  output slot_t slot
);
  frame_t              sh;
  frame_t              sh_nx;
  logic [CNT_BITS-1:0] cnt;
  logic                active, is_sub0, last;

  assign sh_nx = {sh[FRAME_BITS-2:0], sdi};
  assign last  = active && (cnt == CNT_BITS'(FRAME_BITS - 1));
  assign push  = last && is_sub0 && en;
  assign slot  = slot_of(sh_nx);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh      <= '0;
      cnt     <= '0;
      active  <= 1'b0;
      is_sub0 <= 1'b0;
    end else if (sync) begin
      cnt     <= '0;
      active  <= 1'b1;
      is_sub0 <= sub0;
    end else if (active) begin
      sh <= sh_nx;
      if (last) active <= 1'b0;
      else      cnt    <= cnt + 1'b1;
    end
  end

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!active && !sync) |=> $stable(sh)); // R8
  AST_PUSH_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !sync) |=> !active); // R8
endmodule

// File: rtl/telecom_data_port.sv
module telecom_data_port
  import tdp_pkg::*;
#(
  parameter int unsigned DEPTH = 8,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          port_en,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [31:0]   wdata,
  output logic [31:0]   rdata,
  input  logic          frm_sync,
  input  logic          frm_sub0,
  input  logic          sdi,
  output logic          sdo,
  output logic          tx_full,
  output logic          tx_empty,
  output logic [CW-1:0] tx_level,
  output logic          rx_full,
  output logic          rx_empty,
  output logic [CW-1:0] rx_level,
  output logic          tx_ovr,
  output logic          tx_urun,
  output logic          rx_ovr,
  output logic          rx_urun
);
  // named internal events
  logic  flush;
  logic  tx_wr_drop, tx_slot_miss, tx_pop;
  logic  rx_cap_push, rx_cap_drop, rx_rd_empty, rx_pop;
  slot_t tx_head, rx_head, rx_cap_slot;

  assign flush       = !port_en;
  assign rx_pop      = rd_en && port_en;
  assign rx_rd_empty = rx_pop && rx_empty;

  tdp_fifo #(.W(SLOT_BITS), .DEPTH(DEPTH)) u_txq (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .push(wr_en), .din(tx_entry(wdata)), .pop(tx_pop),
    .dout(tx_head), .full(tx_full), .empty(tx_empty),
    .level(tx_level), .drop(tx_wr_drop)
  );

  tdp_fifo #(.W(SLOT_BITS), .DEPTH(DEPTH)) u_rxq (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .push(rx_cap_push), .din(rx_cap_slot), .pop(rx_pop),
    .dout(rx_head), .full(rx_full), .empty(rx_empty),
    .level(rx_level), .drop(rx_cap_drop)
  );

  tdp_txfrm u_tx (
    .clk(clk), .rst_n(rst_n), .en(port_en),
    .sync(frm_sync), .sub0(frm_sub0),
    .head(tx_head), .empty(tx_empty),
    .pop(tx_pop), .slot_miss(tx_slot_miss), .sdo(sdo)
  );

  tdp_rxcap u_rx (
    .clk(clk), .rst_n(rst_n), .en(port_en),
    .sync(frm_sync), .sub0(frm_sub0), .sdi(sdi),
    .push(rx_cap_push), .slot(rx_cap_slot)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)      rdata <= '0;
    else if (rd_en)  rdata <= (port_en && !rx_empty) ? bus_word(rx_head) : '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      tx_ovr  <= 1'b0;
      tx_urun <= 1'b0;
      rx_ovr  <= 1'b0;
      rx_urun <= 1'b0;
    end else begin
      tx_ovr  <= tx_ovr  | tx_wr_drop;
      tx_urun <= tx_urun | tx_slot_miss;
      rx_ovr  <= rx_ovr  | rx_cap_drop;
      rx_urun <= rx_urun | rx_rd_empty;
    end
  end

  AST_RDATA_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    (rdata[31:16] == '0) && (rdata[1:0] == 2'b00)); // R2
  AST_TX_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_ovr && port_en) |=> (tx_ovr || !port_en)); // R4
  AST_RX_OVR_ON_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_cap_drop && port_en) |=> (rx_ovr || !port_en)); // R9
  AST_URUN_ON_EMPTY_READ: assert property (@(posedge clk) disable iff (!rst_n)
    rx_rd_empty |=> (rx_urun && rdata == '0) || !port_en); // R5
  AST_TX_MISS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    tx_slot_miss |=> (tx_urun || !port_en)); // R7
  AST_DISABLED_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    !port_en |=> (tx_empty && rx_empty && !tx_ovr && !rx_ovr && !tx_urun && !rx_urun)); // R10
  AST_RX_ENTRY_LOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_empty |-> (rx_head[1:0] == 2'b00)); // R8
endmodule

// File: tb/sim_telecom_data_port.sv
module sim_telecom_data_port;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        port_en = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        frm_sync = 1'b0, frm_sub0 = 1'b0, sdi = 1'b0;
  logic        sdo, tx_full, tx_empty, rx_full, rx_empty;
  logic [3:0]  tx_level, rx_level;
  logic        tx_ovr, tx_urun, rx_ovr, rx_urun;

  int errs = 0;
  int checks = 0;
  bit done = 0;
  logic [15:0] txq[$];
  logic [15:0] rxq[$];
  logic        mon_rd = 1'b0;

  always #4 clk = ~clk;

  telecom_data_port u0 (
    .clk(clk), .rst_n(rst_n), .port_en(port_en), .wr_en(wr_en), .rd_en(rd_en),
    .wdata(wdata), .rdata(rdata), .frm_sync(frm_sync), .frm_sub0(frm_sub0),
    .sdi(sdi), .sdo(sdo), .tx_full(tx_full), .tx_empty(tx_empty),
    .tx_level(tx_level), .rx_full(rx_full), .rx_empty(rx_empty),
    .rx_level(rx_level), .tx_ovr(tx_ovr), .tx_urun(tx_urun),
    .rx_ovr(rx_ovr), .rx_urun(rx_urun)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Read monitor: rdata is valid at the negedge after the sampling edge (R2, R5)
  always @(posedge clk) mon_rd <= rd_en;
  always @(negedge clk) begin
    if (mon_rd) begin
      logic [31:0] e;
      e = '0;
      if (rxq.size() > 0) e = {16'h0, rxq.pop_front()};
      chk("R2/R5 read data", {32'h0, rdata}, {32'h0, e});
    end
  end

  task automatic bus_wr(input logic [31:0] v);
    @(negedge clk) wr_en = 1'b1; wdata = v;
    if (port_en && txq.size() < 8) txq.push_back({v[15:2], 2'b00});
    @(negedge clk) wr_en = 1'b0; wdata = '0;
  endtask

  task automatic bus_rd();
    @(negedge clk) rd_en = 1'b1;
    @(negedge clk) rd_en = 1'b0;
    @(negedge clk);
  endtask

  // One subframe: transmit check plus receive model (R6, R7, R8, R9)
  task automatic frame(input bit s0, input logic [63:0] rxf);
    logic [63:0] got;
    logic [15:0] es;
    @(negedge clk) frm_sync = 1'b1; frm_sub0 = s0;
    es = '0;
    if (s0 && port_en && txq.size() > 0) es = txq.pop_front();
    for (int k = 1; k <= 64; k++) begin
      @(negedge clk) frm_sync = 1'b0;
      got[64-k] = sdo;
      sdi = rxf[64-k];
    end
    @(negedge clk) sdi = 1'b0;
    chk("R6 sdo frame", got, {16'h0, es, 32'h0});
    if (s0 && port_en && rxq.size() < 8) rxq.push_back({rxf[47:34], 2'b00});
  endtask

  task automatic drain_rx();
    while (rxq.size() > 0) bus_rd();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1; port_en = 1'b1;
    @(negedge clk);
    chk("R10 reset rdata", {32'h0, rdata}, 64'h0);
    chk("R10 reset empties", {62'h0, tx_empty, rx_empty}, 64'h3);
    chk("R10 reset flags", {60'h0, tx_ovr, tx_urun, rx_ovr, rx_urun}, 64'h0);

    // R1, R6: reserved and low bits ignored, slot position
    bus_wr(32'hABCD_FFFF);
    chk("R3 tx level one", {60'h0, tx_level}, 64'd1);
    frame(1'b1, 64'h0);
    drain_rx();

    // R3 order, R6 subframe 1 silent and not popping
    bus_wr(32'h0000_1235); bus_wr(32'hFFFF_8001); bus_wr(32'h1234_4446);
    frame(1'b0, 64'hFFFF_FFFF_FFFF_FFFF);
    chk("R6 sub1 no pop", {60'h0, tx_level}, 64'd3);
    chk("R8 sub1 no capture", {63'h0, rx_empty}, 64'd1);
    for (int i = 0; i < 3; i++) frame(1'b1, 64'h0);
    chk("R7 no urun yet", {63'h0, tx_urun}, 64'd0);
    frame(1'b1, 64'h0);
    chk("R7 tx_urun set", {63'h0, tx_urun}, 64'd1);
    drain_rx();
    chk("R3 rx empty after drain", {63'h0, rx_empty}, 64'd1);

    // R8 capture with noise outside the slot and low bits set
    frame(1'b1, 64'h5A5A_F00F_C3C3_A5A5);
    frame(1'b1, 64'hFFFF_0003_FFFF_FFFF);
    frame(1'b1, 64'h0000_8000_0000_0000);
    chk("R8 rx level", {60'h0, rx_level}, 64'd3);
    drain_rx();

    // R5 read from empty
    bus_rd();
    chk("R5 rx_urun set", {63'h0, rx_urun}, 64'd1);

    // R3, R4 fill transmit
    for (int i = 0; i < 8; i++) bus_wr(32'h0000_1000 * i + 32'h0000_0104 + i);
    chk("R3 tx full", {59'h0, tx_full, tx_level}, {59'h0, 1'b1, 4'd8});
    chk("R4 no ovr yet", {63'h0, tx_ovr}, 64'd0);
    bus_wr(32'h0000_7777);
    chk("R4 tx_ovr set", {63'h0, tx_ovr}, 64'd1);
    chk("R4 level held", {60'h0, tx_level}, 64'd8);
    // drain transmit while filling receive (R3, R9)
    for (int i = 0; i < 8; i++) frame(1'b1, {16'h1111, 16'h0400 * i + 16'h0008, 32'hFFFF_0000});
    chk("R3 rx full", {63'h0, rx_full}, 64'd1);
    chk("R9 no rx_ovr yet", {63'h0, rx_ovr}, 64'd0);
    frame(1'b1, 64'h0000_ABCC_0000_0000);
    chk("R9 rx_ovr set", {63'h0, rx_ovr}, 64'd1);
    chk("R9 rx level held", {60'h0, rx_level}, 64'd8);
    drain_rx();

    // R10 disable flushes and blocks
    bus_wr(32'h0000_2220); bus_wr(32'h0000_3330);
    frame(1'b0, 64'h0);
    frame(1'b1, 64'h0000_9990_0000_0000);
    bus_wr(32'h0000_4440);
    @(negedge clk) port_en = 1'b0;
    txq.delete(); rxq.delete();
    @(negedge clk);
    chk("R10 flush empties", {62'h0, tx_empty, rx_empty}, 64'h3);
    chk("R10 flush flags", {60'h0, tx_ovr, tx_urun, rx_ovr, rx_urun}, 64'h0);
    bus_wr(32'h0000_5550);
    chk("R10 write ignored", {63'h0, tx_empty}, 64'd1);
    frame(1'b1, 64'h0000_6660_0000_0000);
    chk("R10 capture ignored", {63'h0, rx_empty}, 64'd1);
    chk("R10 no urun when off", {63'h0, tx_urun}, 64'd0);
    @(negedge clk) port_en = 1'b1;
    frame(1'b1, 64'h0);
    chk("R10 reenabled empty slot flags urun", {63'h0, tx_urun}, 64'd1);
    drain_rx();

    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errs++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end
endmodule